// File: doc/BRIEF.md
# Bit Test-and-Complement Execution Unit

This unit runs a single-bit test-and-complement operation. It picks one bit of an operand by an offset and reports that bit's old value on a carry output. It then returns the operand with that bit inverted and every other bit unchanged. The operand is either a 16-bit or 32-bit register value or a bit string in byte-addressed memory. A small opcode decoder turns the raw opcode bytes into an operation select. Only the two test-and-complement encodings start an operation.

In register mode the operation is purely combinational. The result and carry appear in the same cycle as the start strobe, and a done pulse follows one cycle later. In memory mode the unit takes the offset as a signed quantity. It therefore reaches bytes before or after the base address. The unit performs a one-byte read-modify-write over a request/acknowledge port and pulses done once the write has been acknowledged. The arithmetic flags other than carry have no defined value for this operation. They are driven to zero and flagged as not valid.

Top module: `bittc_unit`

## Requirements
- R1: An operation starts only when `op_esc`=8'h0F and either `op_main`=8'hBB (offset taken from `offset_reg`) or `op_main`=8'hBA with `op_grp`=3'd7 (offset taken from `imm8`). Any other encoding with `start` high produces no `done` pulse and no memory request.
- R2: `cf` equals the value the selected bit had before the operation.
- R3: In register mode `result` equals `reg_operand` with exactly the selected bit inverted.
- R4: With `wide`=0 the register-mode bit index is offset mod 16, and `result[31:16]` equals `reg_operand[31:16]`. With `wide`=1 the index is offset mod 32.
- R5: In the immediate form only `imm8[4:0]` is used, so the offset is 0 to 31 and `imm8[7:5]` have no effect.
- R6: In register mode `result` and `cf` are valid in the cycle in which `start` is high. `done` is high for exactly the following cycle, and `result`/`cf` hold their values afterwards.
- R7: In memory mode the byte address is `mem_base` + (offset arithmetically shifted right by 3), taken modulo 2^ADDR_W, and the bit within that byte is offset[2:0]. A register offset is signed 32-bit.
- R8: A memory operation first issues a read (`mem_req`=1, `mem_we`=0) until `mem_ack`. It then writes (`mem_we`=1) the read byte with the selected bit inverted until `mem_ack`. After that `done` pulses for one cycle with `cf` valid and `result[7:0]` set to the written byte. Exactly one write occurs per operation.
- R9: While `busy` is high, `start` is ignored: it causes no extra memory access and does not change the address in use.
- R10: After reset `busy`, `done` and `mem_req` are 0.
- R11: `flags_undef` is always 5'b00000 and `flags_undef_mask` is always 5'b11111, which marks those flags as not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation start strobe |
| op_esc | input | 8 | First opcode byte |
| op_main | input | 8 | Second opcode byte |
| op_grp | input | 3 | Register field of the operand-specifier byte |
| wide | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| mem_mode | input | 1 | 1 = bit string in memory, 0 = register operand |
| reg_operand | input | 32 | Register bit base value |
| offset_reg | input | 32 | Register-supplied bit offset |
| imm8 | input | 8 | Immediate bit offset |
| mem_base | input | ADDR_W | Byte address of string bit 0 |
| result | output | 32 | Operand with selected bit inverted |
| cf | output | 1 | Old value of the selected bit |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Memory sequence in progress |
| flags_undef | output | 5 | Undefined arithmetic flags, driven 0 |
| flags_undef_mask | output | 5 | Not-valid mask for those flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| mem_ack | input | 1 | Access acknowledge |

## Verification
Register-mode tests use offsets below 16, offsets between 16 and 31, and offsets above 31 in both operand sizes. These tell modulo-16 reduction apart from modulo-32 reduction, and show whether the upper half survives a 16-bit operation. Selected bits of both 0 and 1 separate a correct carry from a constant one. Memory tests use small positive and negative offsets, the extreme signed values and a saturated immediate. These show whether the shift is arithmetic, whether the bit index wraps correctly across bytes, and whether the immediate is cut to five bits. Undecodable encodings and starts issued during a busy sequence confirm that nothing is written when nothing should be.

// File: rtl/bittc_pkg.sv
package bittc_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int NFLAG  = 5;

  localparam logic [7:0] OPC_ESCAPE = 8'h0F;
  localparam logic [7:0] OPC_REGOFF = 8'hBB;
  localparam logic [7:0] OPC_GROUP  = 8'hBA;
  localparam logic [2:0] GRP_TESTC  = 3'd7;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_REGOFF,
    SEL_IMMOFF
  } opsel_t;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_READ,
    MS_MODIFY,
    MS_WRITE,
    MS_DONE
  } mstate_t;
endpackage

// File: rtl/bittc_decode.sv
module bittc_decode
  import bittc_pkg::*;
(
  input  logic [7:0] op_esc,
  input  logic [7:0] op_main,
  input  logic [2:0] op_grp,
  output opsel_t     opsel
);
  always_comb begin
    opsel = SEL_NONE;
    if (op_esc == OPC_ESCAPE) begin
      if (op_main == OPC_REGOFF)
        opsel = SEL_REGOFF;
      else if (op_main == OPC_GROUP && op_grp == GRP_TESTC)
        opsel = SEL_IMMOFF;
    end
  end
endmodule

// File: rtl/bittc_regpath.sv
module bittc_regpath
  import bittc_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  offset,
  input  logic              wide,
  output logic [DATA_W-1:0] result,
  output logic              cf
);
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] flip;

  always_comb begin
    if (wide)
      idx = offset;
    else
      idx = {1'b0, offset[IDX_W-2:0]};
    flip   = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
    result = operand ^ flip;
    cf     = operand[idx];
  end
endmodule

// File: rtl/bittc_memseq.sv
module bittc_memseq
  import bittc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              busy,
  output logic              done,
  output logic              cf,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int SHIFT = BIT_W;

  mstate_t             state_q, state_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [BIT_W-1:0]    bit_q;
  logic [BYTE_W-1:0]   rd_q;
  logic [BYTE_W-1:0]   wr_q;
  logic                cf_q;

  logic signed [DATA_W-1:0] off_s;
  logic [ADDR_W-1:0]        step;
  logic [ADDR_W-1:0]        addr_d;
  logic                     load_en, rd_en, mod_en;

  assign off_s  = $signed(offset);
  assign step   = ADDR_W'(off_s >>> SHIFT);
  assign addr_d = base + step;

  assign load_en = (state_q == MS_IDLE) && go;
  assign rd_en   = (state_q == MS_READ) && mem_ack;
  assign mod_en  = (state_q == MS_MODIFY);

  always_comb begin
    state_d = state_q;
    case (state_q)
      MS_IDLE:   if (go) state_d = MS_READ;
      MS_READ:   if (mem_ack) state_d = MS_MODIFY;
      MS_MODIFY: state_d = MS_WRITE;
      MS_WRITE:  if (mem_ack) state_d = MS_DONE;
      MS_DONE:   state_d = MS_IDLE;
      default:   state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= MS_IDLE;
    else
      state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bit_q  <= '0;
    end else if (load_en) begin
      addr_q <= addr_d;
      bit_q  <= offset[BIT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_q <= '0;
    else if (rd_en)
      rd_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      cf_q <= 1'b0;
    end else if (mod_en) begin
      wr_q <= rd_q ^ (BYTE_W'(1) << bit_q);
      cf_q <= rd_q[bit_q];
    end
  end

  assign mem_req   = (state_q == MS_READ) || (state_q == MS_WRITE);
  assign mem_we    = (state_q == MS_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wr_q;
  assign busy      = (state_q != MS_IDLE);
  assign done      = (state_q == MS_DONE);
  assign cf        = cf_q;
  assign byte_out  = wr_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(mem_addr)); // R9
  AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we) |-> ($countones(mem_wdata ^ rd_q) == 1)); // R8
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && !$past(mem_we)) |-> $past(state_q == MS_MODIFY)); // R8
endmodule

// File: rtl/bittc_unit.sv
module bittc_unit
  import bittc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        op_esc,
  input  logic [7:0]        op_main,
  input  logic [2:0]        op_grp,
  input  logic              wide,
  input  logic              mem_mode,
  input  logic [31:0]       reg_operand,
  input  logic [31:0]       offset_reg,
  input  logic [7:0]        imm8,
  input  logic [ADDR_W-1:0] mem_base,
  output logic [31:0]       result,
  output logic              cf,
  output logic              done,
  output logic              busy,
  output logic [4:0]        flags_undef,
  output logic [4:0]        flags_undef_mask,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);
  opsel_t              opsel;
  logic [DATA_W-1:0]   off_sel;
  logic                fire, reg_fire, mem_go;
  logic [DATA_W-1:0]   reg_res;
  logic                reg_cf;
  logic                mem_done, mem_cf, mem_busy;
  logic [BYTE_W-1:0]   mem_byte;
  logic [DATA_W-1:0]   res_q;
  logic                cf_q;
  logic                rdone_q;
  logic                unused_imm_hi;

  bittc_decode u_dec (
    .op_esc  (op_esc),
    .op_main (op_main),
    .op_grp  (op_grp),
    .opsel   (opsel)
  );

  assign unused_imm_hi = ^imm8[7:5];
  assign off_sel = (opsel == SEL_IMMOFF) ? {{(DATA_W-5){1'b0}}, imm8[4:0]} : offset_reg;

  assign fire     = start && (opsel != SEL_NONE) && !mem_busy;
  assign reg_fire = fire && !mem_mode;
  assign mem_go   = fire && mem_mode;

  bittc_regpath u_reg (
    .operand (reg_operand),
    .offset  (off_sel[IDX_W-1:0]),
    .wide    (wide),
    .result  (reg_res),
    .cf      (reg_cf)
  );

  bittc_memseq #(.ADDR_W(ADDR_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (mem_go),
    .base      (mem_base),
    .offset    (off_sel),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .busy      (mem_busy),
    .done      (mem_done),
    .cf        (mem_cf),
    .byte_out  (mem_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdone_q <= 1'b0;
    else
      rdone_q <= reg_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cf_q  <= 1'b0;
    end else if (reg_fire) begin
      res_q <= reg_res;
      cf_q  <= reg_cf;
    end else if (mem_done) begin
      res_q <= {{(DATA_W-BYTE_W){1'b0}}, mem_byte};
      cf_q  <= mem_cf;
    end
  end

  always_comb begin
    if (reg_fire) begin
      result = reg_res;
      cf     = reg_cf;
    end else if (mem_done) begin
      result = {{(DATA_W-BYTE_W){1'b0}}, mem_byte};
      cf     = mem_cf;
    end else begin
      result = res_q;
      cf     = cf_q;
    end
  end

  assign done             = rdone_q || mem_done;
  assign busy             = mem_busy;
  assign flags_undef      = '0;
  assign flags_undef_mask = '1;

  AST_REG_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) reg_fire |-> ($countones(result ^ reg_operand) == 1)); // R3
  AST_REG_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) reg_fire |=> done); // R6
  AST_NO_FIRE_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n) (start && opsel == SEL_NONE && !busy) |=> !done); // R1
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($past(reg_fire) && !reg_fire && !mem_done) |-> $stable(result)); // R6
endmodule

// File: tb/bittc_unit_test.sv
module bittc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  op_esc, op_main;
  logic [2:0]  op_grp;
  logic        wide, mem_mode;
  logic [31:0] reg_operand, offset_reg;
  logic [7:0]  imm8;
  logic [31:0] mem_base;
  logic [31:0] result;
  logic        cf, done, busy;
  logic [4:0]  flags_undef, flags_undef_mask;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack;

  logic [7:0]  mem [256];
  int          wr_cnt;
  logic [31:0] last_wr_addr;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  bittc_unit #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_esc(op_esc), .op_main(op_main),
    .op_grp(op_grp), .wide(wide), .mem_mode(mem_mode), .reg_operand(reg_operand),
    .offset_reg(offset_reg), .imm8(imm8), .mem_base(mem_base), .result(result),
    .cf(cf), .done(done), .busy(busy), .flags_undef(flags_undef),
    .flags_undef_mask(flags_undef_mask), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack      <= 1'b0;
      mem_rdata    <= 8'h00;
      wr_cnt       <= 0;
      last_wr_addr <= 32'h0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 29 + 7);
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wr_cnt             <= wr_cnt + 1;
        last_wr_addr       <= mem_addr;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_op(input bit immf);
    op_esc  = 8'h0F;
    op_main = immf ? 8'hBA : 8'hBB;
    op_grp  = immf ? 3'd7 : 3'd2;
  endtask

  task automatic run_reg(input bit immf, input bit w, input logic [31:0] opnd,
                         input logic [31:0] offv, input logic [7:0] im, input string tag);
    int idx;
    logic [31:0] exp_res;
    logic exp_cf;
    idx = immf ? int'(im[4:0]) : int'(offv[4:0]);
    if (!w) idx = idx % 16;
    exp_res = opnd ^ (32'h1 << idx);
    exp_cf  = opnd[idx];
    @(negedge clk);
    set_op(immf);
    wide = w; mem_mode = 1'b0; reg_operand = opnd; offset_reg = offv; imm8 = im;
    start = 1'b1;
    #1;
    chk(result == exp_res, {tag, " R3 R4 result same cycle (R6)"}, result, exp_res);
    chk(cf == exp_cf, {tag, " R2 cf"}, 32'(cf), 32'(exp_cf));
    if (!w) chk(result[31:16] == opnd[31:16], {tag, " R4 upper half kept"}, result, opnd);
    chk(flags_undef == 5'b0 && flags_undef_mask == 5'b11111, {tag, " R11 flags"},
        {22'b0, flags_undef, flags_undef_mask}, {22'b0, 5'b0, 5'b11111});
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, {tag, " R6 done next cycle"}, 32'(done), 32'd1);
    chk(result == exp_res && cf == exp_cf, {tag, " R6 hold"}, result, exp_res);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done one cycle"}, 32'(done), 32'd0);
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 30 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_mem(input bit immf, input logic [31:0] base, input logic [31:0] offv,
                         input logic [7:0] im, input string tag);
    logic [31:0] eff, ea;
    logic [7:0]  old, nb, expb;
    int          bitn, w0;
    bit          seen;
    eff  = immf ? {27'b0, im[4:0]} : offv;
    ea   = base + 32'($signed(eff) >>> 3);
    bitn = int'(eff[2:0]);
    old  = mem[ea[7:0]];
    nb   = mem[8'(ea[7:0] + 8'd1)];
    expb = old ^ (8'h1 << bitn);
    w0   = wr_cnt;
    @(negedge clk);
    set_op(immf);
    mem_mode = 1'b1; wide = 1'b1; mem_base = base; offset_reg = offv; imm8 = im;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && mem_req == 1'b1 && mem_we == 1'b0, {tag, " R8 read first"},
        {29'b0, busy, mem_req, mem_we}, 32'b110);
    wait_done(seen);
    chk(seen, {tag, " R8 done pulse"}, 32'(seen), 32'd1);
    chk(cf == old[bitn], {tag, " R2 cf"}, 32'(cf), 32'(old[bitn]));
    chk(result[7:0] == expb, {tag, " R8 result byte"}, result, 32'(expb));
    @(negedge clk);
    chk(mem[ea[7:0]] == expb, {tag, " R7 R8 target byte"}, 32'(mem[ea[7:0]]), 32'(expb));
    chk(mem[8'(ea[7:0] + 8'd1)] == nb, {tag, " R8 neighbour"}, 32'(mem[8'(ea[7:0] + 8'd1)]), 32'(nb));
    chk(last_wr_addr == ea && wr_cnt == w0 + 1, {tag, " R7 address, one write"}, last_wr_addr, ea);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R8 back to idle"}, {30'b0, done, busy}, 32'b0);
  endtask

  task automatic t_bad_op;
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    op_esc = 8'h0F; op_main = 8'hBA; op_grp = 3'd5; mem_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    op_esc = 8'h0E; op_main = 8'hBB; mem_mode = 1'b1;
    chk(done == 1'b0, "R1 bad group field no done", 32'(done), 32'd0);
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && mem_req == 1'b0, "R1 bad escape byte no request",
        {30'b0, done, mem_req}, 32'b0);
    @(negedge clk);
    chk(busy == 1'b0 && wr_cnt == w0, "R1 nothing written", 32'(wr_cnt), 32'(w0));
  endtask

  task automatic t_busy;
    logic [31:0] ea;
    logic [7:0]  other;
    int          w0;
    bit          seen;
    ea    = 32'h0000_0040 + 32'd1;
    other = mem[8'hC0];
    w0    = wr_cnt;
    @(negedge clk);
    set_op(1'b0);
    mem_mode = 1'b1; mem_base = 32'h0000_0040; offset_reg = 32'd12; start = 1'b1;
    @(negedge clk);
    mem_base = 32'h0000_00C0; offset_reg = 32'd0;
    chk(busy == 1'b1, "R9 busy during sequence", 32'(busy), 32'd1);
    wait_done(seen);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(wr_cnt == w0 + 1 && last_wr_addr == ea, "R9 start while busy ignored",
        last_wr_addr, ea);
    chk(mem[8'hC0] == other, "R9 second target untouched", 32'(mem[8'hC0]), 32'(other));
    start = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_esc = 8'h00; op_main = 8'h00; op_grp = 3'd0;
    wide = 1'b1; mem_mode = 1'b0; reg_operand = 32'h0; offset_reg = 32'h0;
    imm8 = 8'h0; mem_base = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R10 reset state",
        {29'b0, busy, done, mem_req}, 32'b0);

    run_reg(1'b0, 1'b1, 32'hA5A5_0F0F, 32'd5,         8'h00, "reg32 off5");
    run_reg(1'b0, 1'b1, 32'h8000_0001, 32'd31,        8'h00, "reg32 off31");
    run_reg(1'b0, 1'b1, 32'h1234_5678, 32'd37,        8'h00, "reg32 off37 mod32 R4");
    run_reg(1'b0, 1'b0, 32'hFFFF_0008, 32'd19,        8'h00, "reg16 off19 mod16 R4");
    run_reg(1'b0, 1'b0, 32'h5555_AAAA, 32'hFFFF_FFFF, 8'h00, "reg16 off-1");
    run_reg(1'b1, 1'b1, 32'h0000_0000, 32'd0,         8'hF7, "imm32 0xF7 R5");
    run_reg(1'b1, 1'b0, 32'hDEAD_BEEF, 32'd0,         8'h3A, "imm16 0x3A R5");
    run_reg(1'b0, 1'b1, 32'hA5A5_0F2F, 32'd5,         8'h00, "reg32 re-flip");

    run_mem(1'b0, 32'h0000_0080, 32'd13,          8'h00, "mem +13");
    run_mem(1'b0, 32'h0000_0080, 32'hFFFF_FFF7,   8'h00, "mem -9 R7");
    run_mem(1'b0, 32'h0000_0080, 32'hFFFF_FFFF,   8'h00, "mem -1 R7");
    run_mem(1'b0, 32'h0000_0080, 32'h7FFF_FFFF,   8'h00, "mem max R7");
    run_mem(1'b0, 32'h0000_0080, 32'h8000_0000,   8'h00, "mem min R7");
    run_mem(1'b1, 32'h0000_0010, 32'hFFFF_FFFF,   8'hFF, "mem imm 0xFF R5");

    t_bad_op();
    t_busy();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule